// File: doc/BRIEF.md
# Power Mode and Oscillator Controller

This block is the system-control unit of a small microcontroller. When the core raises a halt request, it picks one of four low-power states from two control bits and one external input, and it drives the CPU clock enable and the system clock enable for that state. A wake-up request in any low-power state returns it to run mode. The CPU clock is held off until the clock source now selected is ready again.

It also manages two oscillators, one high-speed and one low-speed. Each one can be a crystal or an internal RC type. Each oscillator has an enable output and a ready flag. The ready flag is modelled as a counter of oscillator cycles, and the inputs `hf_tick` and `lf_tick` each pulse once per oscillator cycle. The block drives the system clock route: either the high-speed clock at full rate, the high-speed clock divided by a power of two, or the low-speed clock. When the low-speed clock is selected, the high-speed oscillator is switched off. A sticky low-voltage-reset flag completes the register set.

Top module: `pwrosc_ctrl`

## Requirements
- R1: A halt request in run mode with idle-enable (PWR bit 5) at 0 enters SLEEP1 (`pmode`=4) when `keep_lf` is 1, and SLEEP0 (`pmode`=3) otherwise. In both sleep states the CPU clock enable and the system clock enable are 0.
- R2: A halt request in run mode with idle-enable at 1 enters IDLE1 (`pmode`=2) when clock-in-idle (SYS bit 7) is 1. In IDLE1 the CPU clock enable is 0 and the system clock enable follows source readiness. With clock-in-idle at 0 it enters IDLE0 (`pmode`=1), where both enables are 0.
- R3: After its enable rises, the high-speed ready flag (PWR bit 7) becomes 1 after 128 `hf_tick` pulses when the high-speed type (SYS bit 6) is 1 (crystal). It becomes 1 after 16 pulses when that bit is 0 (RC). One pulse fewer leaves it at 0.
- R4: The high-speed ready flag reads 0 in SLEEP0, SLEEP1 and IDLE0, and whenever the high-speed oscillator is disabled.
- R5: The low-speed ready flag (PWR bit 6) becomes 1 after 128 `lf_tick` pulses when the low-speed type (SYS bit 5) is 1, and after 2 pulses when it is 0. The low-speed oscillator is disabled only in SLEEP0, and the flag reads 0 there.
- R6: With clock-select (PWR bit 4) at 0, the route code (PWR bits 2:0) selects fH/2 to fH/64 for codes 0 to 5 (`sel_lf`=0) and the low-speed clock for codes 6 and 7 (`sel_lf`=1). `div_code` outputs the code, and `sel_fh` outputs the clock-select bit.
- R7: Whenever the low-speed clock is routed, `hosc_en` is 0.
- R8: A wake-up request outside run mode returns to run mode (`pmode`=0). A halt outside run mode and a wake-up in run mode are ignored. `cpu_clk_en` is 1 only in run mode while the ready flag of the routed source is 1.
- R9: The low-voltage-reset flag (SYS bit 0) is set by `lvr_evt`. Writing 1 to it leaves it unchanged, and writing 0 clears it, except in a cycle where the event also occurs, in which case the event wins.
- R10: Register PWR (address 0) resets to 0x10 and SYS (address 1) resets to 0x00. PWR bit 3 and SYS bits 4:1 read 0. Writes to the two ready bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 PWR, 1 SYS |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| halt_req | input | 1 | Halt request from the core |
| wake_req | input | 1 | Wake-up event |
| keep_lf | input | 1 | Keep the low-speed oscillator on during sleep |
| lvr_evt | input | 1 | Low-voltage reset event |
| hf_tick | input | 1 | One pulse per high-speed oscillator cycle |
| lf_tick | input | 1 | One pulse per low-speed oscillator cycle |
| hosc_en | output | 1 | High-speed oscillator enable |
| losc_en | output | 1 | Low-speed oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| sys_clk_en | output | 1 | System clock gate enable |
| sel_fh | output | 1 | System clock is undivided fH |
| sel_lf | output | 1 | Divided path takes the low-speed clock |
| div_code | output | 3 | Route code to the divider |
| pmode | output | 3 | Current power state |

## Verification
The assertions assume the following about the inputs:
- `hf_tick` and `lf_tick` are single-cycle strobes.
- A low-voltage event is a level that a register write may meet in the same cycle.
- Halt and wake-up are never needed together for a defined result.

The bench drives every input after the falling clock edge. It pulses halt and wake-up for exactly one cycle each and never raises them together. It gives tick pulses only through a counting task, so the number of oscillator cycles seen after each enable is exactly known.

// File: rtl/pwrosc_pkg.sv
// Shared types and constants of the power-mode and oscillator controller.
// Assumes a single clock domain; oscillator cycles arrive as tick strobes.
package pwrosc_pkg;
    typedef enum logic [2:0] {
        PM_RUN    = 3'd0,
        PM_IDLE0  = 3'd1,
        PM_IDLE1  = 3'd2,
        PM_SLEEP0 = 3'd3,
        PM_SLEEP1 = 3'd4
    } pmode_t;

    localparam int REG_W       = 8;
    localparam int ROUTE_W     = 3;
    localparam int LF_CODE_MIN = 6;
endpackage

// File: rtl/osc_ready_seq.sv
// Ready sequencer of one oscillator: counts oscillator ticks after enable
// and raises the ready flag once the type-dependent count is reached.
// Assumes tick is a one-cycle strobe; the flag is forced low while disabled.
module osc_ready_seq #(
    parameter int XTAL_CYC = 128,
    parameter int RC_CYC   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic tick,
    input  logic is_xtal,
    output logic rdy
);
    localparam int MAXC  = (XTAL_CYC > RC_CYC) ? XTAL_CYC : RC_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] lim;
    logic             rdy_q;

    // Pick the startup length from the oscillator type.
    assign lim = is_xtal ? CNT_W'(XTAL_CYC) : CNT_W'(RC_CYC);
    assign nxt = cnt + CNT_W'(1);

    // Count ticks while enabled; clear everything when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !osc_en) begin
            cnt   <= '0;
            rdy_q <= 1'b0;
        end else if (tick && !rdy_q) begin
            cnt <= nxt;
            if (nxt >= lim) rdy_q <= 1'b1;
        end
    end

    // The flag never reads 1 while the oscillator is off.
    assign rdy = rdy_q && osc_en;
endmodule

// File: rtl/pwr_mode_fsm.sv
// Power state machine: chooses the low-power state on halt and returns
// to run on wake-up. Assumes halt and wake are sampled once per cycle.
module pwr_mode_fsm
    import pwrosc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   halt_req,
    input  logic   wake_req,
    input  logic   idle_en,
    input  logic   sysclk_idle,
    input  logic   keep_lf,
    output pmode_t mode
);
    pmode_t halt_tgt;

    // Target state for a halt, from the two control bits and keep_lf.
    always_comb begin
        if (idle_en) halt_tgt = sysclk_idle ? PM_IDLE1 : PM_IDLE0;
        else         halt_tgt = keep_lf ? PM_SLEEP1 : PM_SLEEP0;
    end

    // State register: halt only in run, wake only outside run.
    always_ff @(posedge clk) begin
        if (!rst_n)                            mode <= PM_RUN;
        else if (mode == PM_RUN && halt_req)   mode <= halt_tgt;
        else if (mode != PM_RUN && wake_req)   mode <= PM_RUN;
    end
endmodule

// File: rtl/pwr_regs.sv
// Register pair: PWR (ready flags, idle enable, clock select, route code)
// and SYS (clock-in-idle, oscillator types, low-voltage-reset flag).
// Assumes reads are combinational and writes take effect at the next edge.
module pwr_regs
    import pwrosc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic               lvr_evt,
    input  logic               hf_rdy,
    input  logic               lf_rdy,
    output logic               idle_en,
    output logic               fh_sel,
    output logic [ROUTE_W-1:0] route,
    output logic               sysclk_idle,
    output logic               hf_xtal,
    output logic               lf_xtal,
    output logic               lvr_flag,
    output logic [REG_W-1:0]   reg_rdata
);
    logic wr_pwr, wr_sys;
    logic unused_wbits;

    assign wr_pwr       = reg_wr && !reg_addr;
    assign wr_sys       = reg_wr &&  reg_addr;
    assign unused_wbits = reg_wdata[3];

    // PWR writable fields; ready bits 7:6 are not stored here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_en <= 1'b0;
            fh_sel  <= 1'b1;
            route   <= '0;
        end else if (wr_pwr) begin
            idle_en <= reg_wdata[5];
            fh_sel  <= reg_wdata[4];
            route   <= reg_wdata[ROUTE_W-1:0];
        end
    end

    // SYS writable fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sysclk_idle <= 1'b0;
            hf_xtal     <= 1'b0;
            lf_xtal     <= 1'b0;
        end else if (wr_sys) begin
            sysclk_idle <= reg_wdata[7];
            hf_xtal     <= reg_wdata[6];
            lf_xtal     <= reg_wdata[5];
        end
    end

    // Sticky low-voltage flag: event sets, a written 0 clears, event wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                         lvr_flag <= 1'b0;
        else if (lvr_evt)                   lvr_flag <= 1'b1;
        else if (wr_sys && !reg_wdata[0])   lvr_flag <= 1'b0;
    end

    // Read mux; unimplemented bits return 0.
    always_comb begin
        if (!reg_addr) reg_rdata = {hf_rdy, lf_rdy, idle_en, fh_sel, 1'b0, route};
        else           reg_rdata = {sysclk_idle, hf_xtal, lf_xtal, 4'b0000, lvr_flag};
    end
endmodule

// File: rtl/pwrosc_ctrl.sv
// Top of the power-mode and oscillator controller. Ties the register pair,
// the power state machine and two ready sequencers together, and derives
// oscillator enables, clock gates and the clock route.
// Assumes hf_tick/lf_tick each pulse once per oscillator cycle.
module pwrosc_ctrl
    import pwrosc_pkg::*;
#(
    parameter int HF_XTAL_CYC = 128,
    parameter int HF_RC_CYC   = 16,
    parameter int LF_XTAL_CYC = 128,
    parameter int LF_RC_CYC   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               halt_req,
    input  logic               wake_req,
    input  logic               keep_lf,
    input  logic               lvr_evt,
    input  logic               hf_tick,
    input  logic               lf_tick,
    output logic               hosc_en,
    output logic               losc_en,
    output logic               cpu_clk_en,
    output logic               sys_clk_en,
    output logic               sel_fh,
    output logic               sel_lf,
    output logic [ROUTE_W-1:0] div_code,
    output logic [2:0]         pmode
);
    pmode_t             mode;
    logic               idle_en, fh_sel, sysclk_idle, hf_xtal, lf_xtal, lvr_flag;
    logic [ROUTE_W-1:0] route;
    logic               hf_rdy, lf_rdy, clk_live, src_rdy;

    pwr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .lvr_evt(lvr_evt), .hf_rdy(hf_rdy), .lf_rdy(lf_rdy),
        .idle_en(idle_en), .fh_sel(fh_sel), .route(route), .sysclk_idle(sysclk_idle),
        .hf_xtal(hf_xtal), .lf_xtal(lf_xtal), .lvr_flag(lvr_flag), .reg_rdata(reg_rdata)
    );

    pwr_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wake_req(wake_req),
        .idle_en(idle_en), .sysclk_idle(sysclk_idle), .keep_lf(keep_lf), .mode(mode)
    );

    osc_ready_seq #(.XTAL_CYC(HF_XTAL_CYC), .RC_CYC(HF_RC_CYC)) u_hf (
        .clk(clk), .rst_n(rst_n), .osc_en(hosc_en), .tick(hf_tick),
        .is_xtal(hf_xtal), .rdy(hf_rdy)
    );

    osc_ready_seq #(.XTAL_CYC(LF_XTAL_CYC), .RC_CYC(LF_RC_CYC)) u_lf (
        .clk(clk), .rst_n(rst_n), .osc_en(losc_en), .tick(lf_tick),
        .is_xtal(lf_xtal), .rdy(lf_rdy)
    );

    // Clock route: undivided fH, divided fH, or the low-speed clock.
    assign sel_fh   = fh_sel;
    assign div_code = route;
    assign sel_lf   = !fh_sel && (route >= ROUTE_W'(LF_CODE_MIN));

    // Oscillator enables and clock gates from state and route.
    assign clk_live   = (mode == PM_RUN) || (mode == PM_IDLE1);
    assign hosc_en    = clk_live && !sel_lf;
    assign losc_en    = (mode != PM_SLEEP0);
    assign src_rdy    = sel_lf ? lf_rdy : hf_rdy;
    assign cpu_clk_en = (mode == PM_RUN) && src_rdy;
    assign sys_clk_en = clk_live && src_rdy;
    assign pmode      = mode;
endmodule

// File: rtl/pwrosc_chk.sv
// Assertion checker for pwrosc_ctrl, attached by bind below.
// Assumes the tick inputs are one-cycle strobes.
module pwrosc_chk
    import pwrosc_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input pmode_t mode,
    input logic   halt_req,
    input logic   wake_req,
    input logic   idle_en,
    input logic   hf_rdy,
    input logic   lf_rdy,
    input logic   hf_tick,
    input logic   hosc_en,
    input logic   sel_lf,
    input logic   cpu_clk_en,
    input logic   sys_clk_en,
    input logic   lvr_evt,
    input logic   lvr_flag,
    input logic   lvr_clr_wr
);
    // R1
    halt_to_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_RUN && halt_req && !idle_en) |=> (mode == PM_SLEEP0 || mode == PM_SLEEP1));

    // R2
    idle0_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_IDLE0) |-> (!sys_clk_en && !cpu_clk_en));

    // R3
    hf_rdy_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hf_rdy) |-> $past(hf_tick));

    // R4
    hf_rdy_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_SLEEP0 || mode == PM_SLEEP1 || mode == PM_IDLE0) |-> !hf_rdy);

    // R5
    lf_rdy_low_sleep0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_SLEEP0) |-> !lf_rdy);

    // R7
    hf_off_on_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lf |-> !hosc_en);

    // R8
    wake_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PM_RUN && wake_req) |=> (mode == PM_RUN));

    // R9
    lvr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvr_evt |=> lvr_flag);

    // R9
    lvr_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lvr_flag) |-> $past(lvr_clr_wr));
endmodule

bind pwrosc_ctrl pwrosc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .halt_req(halt_req), .wake_req(wake_req),
    .idle_en(idle_en), .hf_rdy(hf_rdy), .lf_rdy(lf_rdy), .hf_tick(hf_tick),
    .hosc_en(hosc_en), .sel_lf(sel_lf), .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en),
    .lvr_evt(lvr_evt), .lvr_flag(lvr_flag),
    .lvr_clr_wr(reg_wr && reg_addr && !reg_wdata[0])
);

// File: tb/pwrosc_ctrl_test.sv
`timescale 1ns/1ps
module pwrosc_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic       halt_req = 1'b0, wake_req = 1'b0, keep_lf = 1'b0, lvr_evt = 1'b0;
    logic       hf_tick = 1'b0, lf_tick = 1'b0;
    logic       hosc_en, losc_en, cpu_clk_en, sys_clk_en, sel_fh, sel_lf;
    logic [2:0] div_code, pmode;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    pwrosc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .halt_req(halt_req),
        .wake_req(wake_req), .keep_lf(keep_lf), .lvr_evt(lvr_evt),
        .hf_tick(hf_tick), .lf_tick(lf_tick), .hosc_en(hosc_en), .losc_en(losc_en),
        .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .sel_fh(sel_fh),
        .sel_lf(sel_lf), .div_code(div_code), .pmode(pmode)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic hticks(input int n);
        for (int i = 0; i < n; i++) begin hf_tick = 1'b1; step(); end
        hf_tick = 1'b0;
    endtask

    task automatic lticks(input int n);
        for (int i = 0; i < n; i++) begin lf_tick = 1'b1; step(); end
        lf_tick = 1'b0;
    endtask

    task automatic halt();
        halt_req = 1'b1; step(); halt_req = 1'b0;
    endtask

    task automatic wake();
        wake_req = 1'b1; step(); wake_req = 1'b0;
    endtask

    initial begin
        logic [7:0] d;
        int em;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10 reset values
        rd(0, d); chk("R10 PWR reset", d, 8'h10);
        rd(1, d); chk("R10 SYS reset", d, 8'h00);
        chk("R8 reset run", pmode, 0);
        chk("R8 cpu off until ready", cpu_clk_en, 0);
        chk("R4 hf enabled after reset", hosc_en, 1);
        chk("R5 lf enabled after reset", losc_en, 1);

        // R3 RC high-speed startup: 16 ticks
        hticks(15); rd(0, d); chk("R3 hf rc 15 ticks", d[7], 0);
        chk("R8 cpu held", cpu_clk_en, 0);
        hticks(1);  rd(0, d); chk("R3 hf rc 16 ticks", d[7], 1);
        chk("R8 cpu released", cpu_clk_en, 1);
        // R5 RC low-speed startup: 2 ticks
        lticks(1); rd(0, d); chk("R5 lf rc 1 tick", d[6], 0);
        lticks(1); rd(0, d); chk("R5 lf rc 2 ticks", d[6], 1);
        // R10 ready bits read-only
        wr(0, 8'h10); rd(0, d); chk("R10 ready bits ignore write", d, 8'hD0);

        // R1 R2 R4 R5 R8 mode sweep
        for (int ie = 0; ie < 2; ie++)
            for (int si = 0; si < 2; si++)
                for (int kl = 0; kl < 2; kl++) begin
                    wr(1, 8'(si << 7));
                    wr(0, 8'((ie << 5) | 8'h10));
                    keep_lf = kl[0];
                    halt();
                    em = ie ? (si ? 2 : 1) : (kl ? 4 : 3);
                    chk(ie ? "R2 idle state" : "R1 sleep state", pmode, em);
                    chk("R1 cpu gated", cpu_clk_en, 0);
                    chk("R2 sys clock", sys_clk_en, (em == 2));
                    chk("R4 hf enable", hosc_en, (em == 2));
                    chk("R5 lf enable", losc_en, (em != 3));
                    rd(0, d);
                    chk("R4 hf ready in low power", d[7], (em == 2));
                    chk("R5 lf ready in low power", d[6], (em != 3));
                    halt(); chk("R8 halt ignored", pmode, em);
                    wake(); chk("R8 wake to run", pmode, 0);
                    chk("R8 cpu waits for ready", cpu_clk_en, (em == 2));
                    hticks(16); lticks(2);
                    chk("R8 cpu after restart", cpu_clk_en, 1);
                    rd(0, d); chk("R3 R5 ready after wake", d[7:6], 2'b11);
                    keep_lf = 1'b0;
                end
        wake(); chk("R8 wake ignored in run", pmode, 0);

        // R3 crystal high-speed: 128 ticks
        wr(1, 8'h40); wr(0, 8'h10);
        halt(); wake();
        hticks(127); rd(0, d); chk("R3 hf xtal 127", d[7], 0);
        chk("R8 cpu held xtal", cpu_clk_en, 0);
        hticks(1); rd(0, d); chk("R3 hf xtal 128", d[7], 1);

        // R5 crystal low-speed: 128 ticks after SLEEP0
        wr(1, 8'h60);
        halt(); chk("R1 sleep0", pmode, 3);
        wake(); hticks(128);
        lticks(127); rd(0, d); chk("R5 lf xtal 127", d[6], 0);
        lticks(1);   rd(0, d); chk("R5 lf xtal 128", d[6], 1);
        wr(1, 8'h00);

        // R6 R7 route sweep
        for (int c = 0; c < 8; c++) begin
            wr(0, 8'(c));
            chk("R6 div code", div_code, c);
            chk("R6 sel_fh", sel_fh, 0);
            chk("R6 sel_lf", sel_lf, (c >= 6));
            chk("R7 hf enable", hosc_en, (c < 6));
            rd(0, d); chk("R4 hf ready by route", d[7], (c < 6));
            chk("R8 cpu on routed source", cpu_clk_en, 1);
        end
        wr(0, 8'h10);
        chk("R6 back to fh", sel_fh, 1);
        chk("R8 cpu waits hf restart", cpu_clk_en, 0);
        hticks(16); chk("R8 cpu after hf restart", cpu_clk_en, 1);

        // R9 low-voltage flag
        lvr_evt = 1'b1; step(); lvr_evt = 1'b0;
        rd(1, d); chk("R9 flag set", d[0], 1);
        wr(1, 8'h01); rd(1, d); chk("R9 write 1 keeps", d[0], 1);
        wr(1, 8'hFF); rd(1, d); chk("R10 SYS unimplemented bits", d, 8'hE1);
        wr(1, 8'h00); rd(1, d); chk("R9 write 0 clears", d, 8'h00);
        lvr_evt = 1'b1; wr(1, 8'h00); lvr_evt = 1'b0;
        rd(1, d); chk("R9 event beats clear", d[0], 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule